// File: doc/BRIEF.md
# Peripheral Security Attribute Register File

This block is a bus-attached bank of configuration registers. For each peripheral it holds one secure attribute bit and one privileged attribute bit, and it drives both out as control signals. It also stores the length fields for four memory watermark regions. Every bus request carries two qualifiers: whether the master is secure, and whether it is privileged. Whether a write may change a bit depends on those two qualifiers and on the bit's paired attribute. A one-way lock bit freezes the whole bank until the next reset.

A global security-enable input switches the security side of the bank on or off. When it is off, the control and security registers do nothing, but the privilege attributes still work. Fixed option inputs can mark a peripheral, or a watermark region, as secure without software. Any write the access rules reject leaves the register unchanged and raises a one-clock illegal-access event. Read data and the bus-error flag are combinational in the request cycle. Write effects and the event appear after the next clock edge.

Top module: `periph_attr_regs`

## Requirements
- R1: Only word requests are accepted (size code 2 = 32-bit; 0 = byte and 1 = halfword). A narrow request asserts `busErr` in the same cycle, reads zero, changes no register and raises no event.
- R2: After reset, the control, security and privilege registers read zero. Each watermark register reads 0x0FFF0000, which means all twelve bits of its length field are set.
- R3: The security register is at offset 0x010 and implements bits 13, 3 and 2. Each bit follows its own rule:
  - a non-secure write never changes it;
  - if its paired privilege bit is set, only a secure privileged write changes it;
  - otherwise any secure write changes it.
- R4: The privilege register is at offset 0x020 and implements bits 13, 4, 3 and 2. A bit whose peripheral is effectively secure (security bit, or `optSec` bit, with `secEnable` high) changes only on a secure privileged write. Otherwise any privileged write changes it. Unprivileged writes never change it.
- R5: The control register is at offset 0x000, with the lock at bit 0.
  - A secure word write with bit 0 set sets the lock. Writing zero never clears it; only reset does.
  - A non-secure write to the control register is rejected.
  - While the lock is set, every write to the security, privilege and watermark registers is rejected.
- R6: Every register can be read by all four qualifier combinations. Reserved bits and unmapped offsets read zero and ignore writes.
- R7: While `secEnable` is low, the control and security registers read zero and ignore writes without raising an event. The privilege register keeps working.
- R8: The watermark registers are at offsets 0x130, 0x134, 0x138 and 0x140, with a 12-bit length in bits 27:16. A write needs a privileged request. When `secEnable` and that region's `wmOptSec` bit are both high, the request must also be secure. Each length is driven on `wmLen[12k+11:12k]`.
- R9: A word write that the rules reject for any implemented bit of its target raises `illegalEvt` for exactly the one cycle after the write.
- R10: `periphSec` is the security register OR `optSec` (restricted to the privilege-register bit set), forced to zero while `secEnable` is low. `periphPriv` equals the privilege register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| secEnable | input | 1 | Global security enable |
| optSec | input | 32 | Fixed per-peripheral secure marks |
| wmOptSec | input | 4 | Fixed secure marks for the watermark regions |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqAddr | input | 12 | Byte offset |
| reqWdata | input | 32 | Write data |
| reqSecure | input | 1 | Request is secure |
| reqPriv | input | 1 | Request is privileged |
| rdata | output | 32 | Read data (combinational) |
| busErr | output | 1 | Narrow-access error (combinational) |
| illegalEvt | output | 1 | One-cycle rejected-write pulse |
| periphSec | output | 32 | Effective peripheral secure attributes |
| periphPriv | output | 32 | Peripheral privileged attributes |
| wmLen | output | 48 | Four 12-bit watermark lengths |

## Verification
The bench builds the block with its default masks: security bits 13, 3 and 2, privilege bits 13, 4, 3 and 2, and four 12-bit watermark fields. With only three or four live bits per register, it can sweep every qualifier combination against both states of the paired attribute and against all-ones, all-zeros and mixed data. It then compares every readback and event against a bit-by-bit rule model. The four watermark regions are likewise swept over both option states and all four qualifier pairs. This reaches every permission outcome, the lock and security-enable corners, and narrow accesses.

// File: rtl/attr_pkg.sv
`timescale 1ns/1ps
package attr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam int NUM_WM = 4;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_SEC  = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_PRIV = 12'h020;
  localparam logic [1:0]        SIZE_WORD = 2'b10;

  function automatic logic [ADDR_W-1:0] wmOffset(input int k);
    case (k)
      0:       return 12'h130;
      1:       return 12'h134;
      2:       return 12'h138;
      default: return 12'h140;
    endcase
  endfunction

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic              rdEn;
    logic              lockSet;
    logic [DATA_W-1:0] secWe;
    logic [DATA_W-1:0] privWe;
    logic [NUM_WM-1:0] wmWe;
    logic              illegal;
  } strobe_t;
endpackage

// File: rtl/attr_ctrl.sv
`timescale 1ns/1ps
module attr_ctrl
  import attr_pkg::*;
#(
  parameter logic [DATA_W-1:0] SEC_MASK  = 32'h0000_200C,
  parameter logic [DATA_W-1:0] PRIV_MASK = 32'h0000_201C
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              lockReq,
  input  logic              reqSecure,
  input  logic              reqPriv,
  input  logic              secEnable,
  input  logic [DATA_W-1:0] optSec,
  input  logic [NUM_WM-1:0] wmOptSec,
  input  logic [DATA_W-1:0] secQ,
  input  logic [DATA_W-1:0] privQ,
  input  logic              lockQ,
  output strobe_t           strb,
  output logic              busErr
);
  logic wordOk, wr;
  logic hitCtrl, hitSec, hitPriv;
  logic [NUM_WM-1:0] hitWm, wmAllow;
  logic [DATA_W-1:0] secAllow, privAllow, secEff;

  assign wordOk  = reqValid && (reqSize == SIZE_WORD);
  assign wr      = wordOk && reqWrite;
  assign busErr  = reqValid && (reqSize != SIZE_WORD);
  assign hitCtrl = (reqAddr == OFF_CTRL);
  assign hitSec  = (reqAddr == OFF_SEC);
  assign hitPriv = (reqAddr == OFF_PRIV);
  assign secEff  = secEnable ? (secQ | optSec) : '0;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bitRule
    assign secAllow[i]  = secEnable && !lockQ && reqSecure && (!privQ[i] || reqPriv);
    assign privAllow[i] = !lockQ && reqPriv && (!secEff[i] || reqSecure);
  end

  for (genvar k = 0; k < NUM_WM; k++) begin : g_wmRule
    assign hitWm[k]   = (reqAddr == wmOffset(k));
    assign wmAllow[k] = !lockQ && reqPriv && (!(secEnable && wmOptSec[k]) || reqSecure);
  end

  always_comb begin
    strb.rdEn    = wordOk && !reqWrite;
    strb.lockSet = wr && hitCtrl && secEnable && reqSecure && lockReq;
    strb.secWe   = (wr && hitSec) ? (secAllow & SEC_MASK) : '0;
    strb.privWe  = (wr && hitPriv) ? (privAllow & PRIV_MASK) : '0;
    strb.wmWe    = wr ? (hitWm & wmAllow) : '0;
    strb.illegal = wr && ((hitCtrl && secEnable && !reqSecure)
                       || (hitSec && secEnable && ((~secAllow & SEC_MASK) != '0))
                       || (hitPriv && ((~privAllow & PRIV_MASK) != '0))
                       || ((hitWm & ~wmAllow) != '0));
  end
endmodule

// File: rtl/attr_datapath.sv
`timescale 1ns/1ps
module attr_datapath
  import attr_pkg::*;
#(
  parameter logic [DATA_W-1:0] PRIV_MASK = 32'h0000_201C,
  parameter int WM_W   = 12,
  parameter int WM_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              secEnable,
  input  logic [DATA_W-1:0] optSec,
  output logic [DATA_W-1:0] secQ,
  output logic [DATA_W-1:0] privQ,
  output logic              lockQ,
  output logic [DATA_W-1:0] rdata,
  output logic              illegalEvt,
  output logic [DATA_W-1:0] periphSec,
  output logic [DATA_W-1:0] periphPriv,
  output logic [NUM_WM*WM_W-1:0] wmLen
);
  localparam logic [WM_W-1:0] WM_RST = '1;

  logic [WM_W-1:0] wmQ [NUM_WM];
  logic [DATA_W-1:0] wmRd [NUM_WM];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ      <= 1'b0;
      secQ       <= '0;
      privQ      <= '0;
      illegalEvt <= 1'b0;
    end else begin
      lockQ      <= lockQ | strb.lockSet;
      secQ       <= (secQ & ~strb.secWe) | (reqWdata & strb.secWe);
      privQ      <= (privQ & ~strb.privWe) | (reqWdata & strb.privWe);
      illegalEvt <= strb.illegal;
    end
  end

  for (genvar k = 0; k < NUM_WM; k++) begin : g_wm
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              wmQ[k] <= WM_RST;
      else if (strb.wmWe[k])  wmQ[k] <= reqWdata[WM_LSB +: WM_W];
    end
    assign wmLen[k*WM_W +: WM_W] = wmQ[k];
    assign wmRd[k] = DATA_W'(wmQ[k]) << WM_LSB;
  end

  always_comb begin
    rdata = '0;
    if (strb.rdEn) begin
      if (reqAddr == OFF_CTRL && secEnable) rdata = {{(DATA_W-1){1'b0}}, lockQ};
      if (reqAddr == OFF_SEC && secEnable)  rdata = secQ;
      if (reqAddr == OFF_PRIV)              rdata = privQ;
      for (int k = 0; k < NUM_WM; k++)
        if (reqAddr == wmOffset(k)) rdata = wmRd[k];
    end
  end

  assign periphSec  = secEnable ? (secQ | (optSec & PRIV_MASK)) : '0;
  assign periphPriv = privQ;
endmodule

// File: rtl/periph_attr_regs.sv
`timescale 1ns/1ps
module periph_attr_regs
  import attr_pkg::*;
#(
  parameter logic [DATA_W-1:0] SEC_MASK  = 32'h0000_200C,
  parameter logic [DATA_W-1:0] PRIV_MASK = 32'h0000_201C,
  parameter int WM_W   = 12,
  parameter int WM_LSB = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   secEnable,
  input  logic [DATA_W-1:0]      optSec,
  input  logic [NUM_WM-1:0]      wmOptSec,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [1:0]             reqSize,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  input  logic                   reqSecure,
  input  logic                   reqPriv,
  output logic [DATA_W-1:0]      rdata,
  output logic                   busErr,
  output logic                   illegalEvt,
  output logic [DATA_W-1:0]      periphSec,
  output logic [DATA_W-1:0]      periphPriv,
  output logic [NUM_WM*WM_W-1:0] wmLen
);
  strobe_t strb;
  logic [DATA_W-1:0] secQ, privQ;
  logic lockQ;

  attr_ctrl #(.SEC_MASK(SEC_MASK), .PRIV_MASK(PRIV_MASK)) i_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr),
    .lockReq(reqWdata[0]), .reqSecure(reqSecure), .reqPriv(reqPriv),
    .secEnable(secEnable), .optSec(optSec), .wmOptSec(wmOptSec),
    .secQ(secQ), .privQ(privQ), .lockQ(lockQ), .strb(strb), .busErr(busErr)
  );

  attr_datapath #(.PRIV_MASK(PRIV_MASK), .WM_W(WM_W), .WM_LSB(WM_LSB)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWdata(reqWdata), .reqAddr(reqAddr),
    .secEnable(secEnable), .optSec(optSec), .secQ(secQ), .privQ(privQ),
    .lockQ(lockQ), .rdata(rdata), .illegalEvt(illegalEvt),
    .periphSec(periphSec), .periphPriv(periphPriv), .wmLen(wmLen)
  );
endmodule

// File: rtl/attr_regs_chk.sv
`timescale 1ns/1ps
module attr_regs_chk (
  input logic        clk,
  input logic        rstN,
  input logic        secEnable,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [1:0]  reqSize,
  input logic [11:0] reqAddr,
  input logic [31:0] rdata,
  input logic        busErr,
  input logic        illegalEvt,
  input logic [31:0] periphPriv,
  input logic        lockQ
);
  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);
  // R5
  locked_priv_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> $stable(periphPriv));
  // R1
  narrow_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize != 2'b10) |-> (busErr && rdata == 32'h0));
  // R1
  narrow_noeffect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize != 2'b10) |=> (!illegalEvt && $stable(periphPriv)));
  // R9
  evt_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalEvt |-> $past(reqValid && reqWrite && reqSize == 2'b10));
  // R7
  secoff_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && !secEnable && (reqAddr == 12'h000 || reqAddr == 12'h010))
      |-> rdata == 32'h0);
endmodule

bind periph_attr_regs attr_regs_chk u_attrChk (
  .clk(clk), .rstN(rstN), .secEnable(secEnable), .reqValid(reqValid),
  .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr), .rdata(rdata),
  .busErr(busErr), .illegalEvt(illegalEvt), .periphPriv(periphPriv), .lockQ(lockQ)
);

// File: tb/test_periph_attr_regs.sv
`timescale 1ns/1ps
module test_periph_attr_regs;
  localparam logic [31:0] SECM  = 32'h0000_200C;
  localparam logic [31:0] PRIVM = 32'h0000_201C;
  localparam logic [11:0] WMOFF [4] = '{12'h130, 12'h134, 12'h138, 12'h140};

  logic clk = 0, rstN = 0, secEnable = 1;
  logic [31:0] optSec = 0;
  logic [3:0]  wmOptSec = 0;
  logic reqValid = 0, reqWrite = 0, reqSecure = 0, reqPriv = 0;
  logic [1:0]  reqSize = 2'b10;
  logic [11:0] reqAddr = 0;
  logic [31:0] reqWdata = 0;
  logic [31:0] rdata, periphSec, periphPriv;
  logic busErr, illegalEvt;
  logic [47:0] wmLen;

  int nChecks = 0, nFail = 0;
  logic [31:0] mSec = 0, mPriv = 0;
  logic mLock = 0;
  logic [11:0] mWm [4] = '{12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF};

  always #4 clk = ~clk;

  periph_attr_regs i_periph_attr_regs (
    .clk(clk), .rstN(rstN), .secEnable(secEnable), .optSec(optSec), .wmOptSec(wmOptSec),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqSecure(reqSecure), .reqPriv(reqPriv), .rdata(rdata),
    .busErr(busErr), .illegalEvt(illegalEvt), .periphSec(periphSec),
    .periphPriv(periphPriv), .wmLen(wmLen)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input bit wr, input logic [11:0] a, input logic [31:0] d,
                       input bit s, input bit p, input logic [1:0] sz);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    reqSecure = s; reqPriv = p; reqSize = sz;
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d, input bit s,
                          input bit p, input logic [1:0] sz, output bit evt, output bit err);
    drive(1, a, d, s, p, sz);
    #1 err = busErr;
    @(negedge clk);
    evt = illegalEvt;
    reqValid = 0;
  endtask

  task automatic busRead(input logic [11:0] a, input bit s, input bit p,
                         output logic [31:0] d);
    drive(0, a, 0, s, p, 2'b10);
    #1 d = rdata;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic doSec(input logic [31:0] d, input bit s, input bit p);
    bit evt, err, bad;
    logic [31:0] rd;
    bad = 0;
    for (int i = 0; i < 32; i++) if (SECM[i] && secEnable) begin
      if (!mLock && s && (!mPriv[i] || p)) mSec[i] = d[i];
      else bad = 1;
    end
    busWrite(12'h010, d, s, p, 2'b10, evt, err);
    check("R9 sec write event", 32'(evt), 32'(bad));
    busRead(12'h010, 0, 0, rd);
    check("R3 sec readback", rd, secEnable ? mSec : 32'h0);
    check("R10 periphSec", periphSec, secEnable ? (mSec | (optSec & PRIVM)) : 32'h0);
  endtask

  task automatic doPriv(input logic [31:0] d, input bit s, input bit p);
    bit evt, err, bad, effS;
    logic [31:0] rd;
    bad = 0;
    for (int i = 0; i < 32; i++) if (PRIVM[i]) begin
      effS = secEnable && (mSec[i] || optSec[i]);
      if (!mLock && p && (!effS || s)) mPriv[i] = d[i];
      else bad = 1;
    end
    busWrite(12'h020, d, s, p, 2'b10, evt, err);
    check("R9 priv write event", 32'(evt), 32'(bad));
    busRead(12'h020, 0, 0, rd);
    check("R4 priv readback", rd, mPriv);
    check("R10 periphPriv", periphPriv, mPriv);
  endtask

  task automatic doWm(input int k, input logic [31:0] d, input bit s, input bit p);
    bit evt, err, ok;
    logic [31:0] rd;
    ok = !mLock && p && (!(secEnable && wmOptSec[k]) || s);
    if (ok) mWm[k] = d[27:16];
    busWrite(WMOFF[k], d, s, p, 2'b10, evt, err);
    check("R9 wm write event", 32'(evt), 32'(!ok));
    busRead(WMOFF[k], s, p, rd);
    check("R8 wm readback", rd, {4'h0, mWm[k], 16'h0});
    check("R8 wmLen port", 32'(wmLen[k*12 +: 12]), 32'(mWm[k]));
  endtask

  task automatic doCtrl(input logic [31:0] d, input bit s);
    bit evt, err;
    logic [31:0] rd;
    if (secEnable && s) mLock = mLock | d[0];
    busWrite(12'h000, d, s, 1, 2'b10, evt, err);
    check("R5 ctrl write event", 32'(evt), 32'(secEnable && !s));
    busRead(12'h000, 1, 1, rd);
    check("R5 lock readback", rd, secEnable ? 32'(mLock) : 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rd, pat;
    bit evt, err;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R2 reset state
    busRead(12'h000, 1, 1, rd); check("R2 ctrl reset", rd, 32'h0);
    busRead(12'h010, 1, 1, rd); check("R2 sec reset", rd, 32'h0);
    busRead(12'h020, 0, 0, rd); check("R2 priv reset", rd, 32'h0);
    for (int k = 0; k < 4; k++) begin
      busRead(WMOFF[k], 0, 1, rd); check("R2 wm reset", rd, 32'h0FFF_0000);
    end
    check("R2 periphSec reset", periphSec, 32'h0);

    // R3 sweep: paired privilege state x qualifiers x data
    for (int ps = 0; ps < 2; ps++)
      for (int q = 0; q < 4; q++)
        for (int dv = 0; dv < 3; dv++) begin
          pat = (dv == 0) ? 32'h0 : (dv == 1) ? 32'hFFFF_FFFF : 32'h0000_2008;
          doSec(32'h0, 1, 1);
          doPriv(ps[0] ? 32'h0000_2004 : 32'h0, 1, 1);
          doSec(pat, q[1], q[0]);
        end

    // R4 sweep: paired security state x qualifiers x data
    for (int ss = 0; ss < 2; ss++)
      for (int q = 0; q < 4; q++)
        for (int dv = 0; dv < 3; dv++) begin
          pat = (dv == 0) ? 32'h0 : (dv == 1) ? 32'hFFFF_FFFF : 32'h0000_2010;
          doPriv(32'h0, 1, 1);
          doSec(ss[0] ? 32'h0000_000C : 32'h0, 1, 1);
          doPriv(pat, q[1], q[0]);
        end

    // R4 / R10: option-marked peripheral on bit 4
    doSec(32'h0, 1, 1);
    doPriv(32'h0, 1, 1);
    optSec = 32'h0000_0010;
    doPriv(32'h0000_0010, 0, 1);
    doPriv(32'h0000_0010, 1, 1);
    check("R10 option secure out", periphSec, 32'h0000_0010);

    // R8 watermark sweep
    for (int k = 0; k < 4; k++)
      for (int o = 0; o < 2; o++)
        for (int q = 0; q < 4; q++) begin
          wmOptSec = o[0] ? (4'b1 << k) : 4'b0;
          doWm(k, 32'hF000_FFFF | (32'(k * 97 + q * 31 + o * 7 + 1) << 16), q[1], q[0]);
        end
    wmOptSec = 0;

    // R1 narrow accesses
    for (int sz = 0; sz < 2; sz++) begin
      busWrite(12'h020, 32'hFFFF_FFFF, 1, 1, 2'(sz), evt, err);
      check("R1 busErr on narrow", 32'(err), 32'h1);
      check("R1 no event on narrow", 32'(evt), 32'h0);
      busRead(12'h020, 1, 1, rd);
      check("R1 narrow write no effect", rd, mPriv);
    end
    busWrite(12'h020, mPriv, 1, 1, 2'b10, evt, err);
    check("R1 word no busErr", 32'(err), 32'h0);

    // R6 unmapped offsets
    busWrite(12'h100, 32'hFFFF_FFFF, 1, 1, 2'b10, evt, err);
    busRead(12'h100, 1, 1, rd); check("R6 unmapped read", rd, 32'h0);
    busRead(12'h014, 0, 0, rd); check("R6 gap read", rd, 32'h0);
    busRead(12'h13C, 0, 1, rd); check("R6 wm gap read", rd, 32'h0);

    // R7 security disabled
    doSec(32'h0000_0004, 1, 1);
    secEnable = 0;
    @(negedge clk);
    check("R7 periphSec gated", periphSec, 32'h0);
    doSec(32'hFFFF_FFFF, 1, 1);
    doCtrl(32'h1, 1);
    doPriv(32'h0000_2004, 0, 1);
    doPriv(32'h0, 0, 0);
    doWm(1, 32'h0ABC_0000, 0, 1);
    secEnable = 1;
    @(negedge clk);
    busRead(12'h010, 1, 1, rd); check("R7 sec kept across disable", rd, mSec);

    // R5 lock
    doCtrl(32'h1, 0);
    doCtrl(32'h1, 1);
    doSec(32'h0, 1, 1);
    doPriv(32'hFFFF_FFFF, 1, 1);
    doWm(2, 32'h0123_0000, 1, 1);
    doCtrl(32'h0, 1);
    check("R5 lock model", 32'(mLock), 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule